// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers interrupt requests from a parameterized set of sources and turns them into a single level request towards a processor. Each source has a flag bit, set by a hardware event, and an enable bit. Sources fold onto a smaller set of vectors. Each vector carries a 3-bit main level and a 2-bit sub-level. In every cycle the controller picks the strongest pending vector. When that vector's main level is above the processor's current level, it raises a registered request that carries the vector number and the main level.

Software reaches all state through a simple word-addressed register bus. Through it, software enables sources, programs vector levels, clears flags once servicing is done, picks single-vector or multi-vector reporting, and sets the edge polarity of a few external pins. A read-only status word keeps the vector and level last presented to the processor.

Top module: `intc_core`

## Requirements
- R1: `irq_req` is high in the cycle after a cycle in which the winning pending vector has a nonzero main level strictly greater than `cpu_ipl`. Otherwise it is low, and the flag stays pending until the level comparison succeeds.
- R2: The level of vector v sits in the bus word at address 0x40 + v/4, in byte v%4: bits [4:2] of that byte hold the main level and bits [1:0] the sub-level. The highest main level wins, and among equal main levels the highest sub-level wins.
- R3: After reset, all flags, enables, levels and control bits are zero and `irq_req` is low. A vector with main level 0 is never delivered.
- R4: When pending vectors have equal main and sub levels, the lowest vector index wins.
- R5: Source s maps to vector floor(s·NUM_VEC/NUM_SRC). A vector is pending when any of its sources is both flagged and enabled. Enables for source s are at address 0x20 + s/32, bit s%32.
- R6: Flags for source s are at address 0x10 + s/32, bit s%32. A write loads the written bits, so 0 clears a flag. A hardware event on `src_evt[s]` sets the flag, and it wins over a clearing write in the same cycle.
- R7: Control bit 0 at address 0x00 selects multi-vector mode (1) or single-vector mode (0, the reset default). In single-vector mode `irq_vec` is 0 for every request.
- R8: External pin i sets the flag of source i. Control bit 8+i selects a rising edge (1) or a falling edge (0). The pin passes through two synchronizing flops, and the flag is set on the third clock edge after the pin changes.
- R9: The status word at address 0x01 holds the last delivered vector in bits [7:0] and its main level in bits [10:8]. It updates whenever `irq_req` goes or stays high, holds otherwise, and bus writes to it have no effect.
- R10: `irq_vec` and `irq_prio` are 0 whenever `irq_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_evt | input | NUM_SRC | Per-source hardware set pulses |
| ext_pin | input | NUM_EXT | Asynchronous external interrupt pins |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| cpu_ipl | input | 3 | Current processor priority level |
| irq_req | output | 1 | Registered interrupt request |
| irq_vec | output | VW | Vector of the request |
| irq_prio | output | 3 | Main level of the request |

## Verification
A corrupted flag, enable or level register is visible on `bus_rdata` in the same cycle its word is addressed. It also changes the winner, and that change reaches `irq_req`/`irq_vec` one clock later. A synchronizer or edge-detect fault shows up three edges after a pin toggle, as a flag that is missing or extra. A stale status register shows up at address 0x01 on the cycle after any delivered request. Because the bench model is compared on every clock, any divergence is reported in the cycle where it first reaches a port.

// File: rtl/intc_pkg.sv
// Package: shared address map, level type and the source-to-vector fold.
// Assumes a 32-bit data bus and 8-bit word addresses.
package intc_pkg;
    localparam int DW = 32;
    localparam int AW = 8;

    localparam logic [AW-1:0] ADDR_CTRL = 8'h00;
    localparam logic [AW-1:0] ADDR_STAT = 8'h01;
    localparam logic [AW-1:0] ADDR_FLAG = 8'h10;
    localparam logic [AW-1:0] ADDR_EN   = 8'h20;
    localparam logic [AW-1:0] ADDR_PRIO = 8'h40;

    localparam int CTRL_MODE_BIT = 0;
    localparam int CTRL_POL_LSB  = 8;

    typedef struct packed {
        logic [2:0] main;
        logic [1:0] sub;
    } prio_t;

    // First source that folds onto vector v (ceil(v*nsrc/nvec)).
    function automatic int first_src(int v, int nsrc, int nvec);
        return (v * nsrc + nvec - 1) / nvec;
    endfunction
endpackage

// File: rtl/intc_ext_edge.sv
// Module: two-flop synchronizer and per-pin edge detector for the external
// interrupt pins. Assumes pins are asynchronous; rise_sel picks the edge.
module intc_ext_edge #(
    parameter int NUM_EXT = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EXT-1:0] pin,
    input  logic [NUM_EXT-1:0] rise_sel,
    output logic [NUM_EXT-1:0] evt
);
    logic [NUM_EXT-1:0] sync1_q, sync2_q, prev_q;

    // Synchronizer chain plus one history stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= '0;
            sync2_q <= '0;
            prev_q  <= '0;
        end else begin
            sync1_q <= pin;
            sync2_q <= sync1_q;
            prev_q  <= sync2_q;
        end
    end

    for (genvar i = 0; i < NUM_EXT; i++) begin : g_edge
        assign evt[i] = rise_sel[i] ? (sync2_q[i] & ~prev_q[i])
                                    : (~sync2_q[i] & prev_q[i]);
    end
endmodule

// File: rtl/intc_src_bank.sv
// Module: per-source flag and enable bits with bus write access.
// Assumes one bus word holds 32 sources; a hardware set beats a clear.
module intc_src_bank
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 96
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] hw_set,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [DW-1:0]      wr_data,
    output logic [NUM_SRC-1:0] flag_q,
    output logic [NUM_SRC-1:0] en_q
);
    logic [NUM_SRC-1:0] flag_d, en_d;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        localparam int WRD = s / 32;
        localparam int BIT = s % 32;
        logic flag_hit, en_hit;
        assign flag_hit  = wr_en && (wr_addr == ADDR_FLAG + AW'(WRD));
        assign en_hit    = wr_en && (wr_addr == ADDR_EN + AW'(WRD));
        assign flag_d[s] = (flag_hit ? wr_data[BIT] : flag_q[s]) | hw_set[s];
        assign en_d[s]   = en_hit ? wr_data[BIT] : en_q[s];
    end

    // Flag and enable storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
            en_q   <= '0;
        end else begin
            flag_q <= flag_d;
            en_q   <= en_d;
        end
    end
endmodule

// File: rtl/intc_arbiter.sv
// Module: folds active sources onto vectors and picks the winner by
// main level, then sub-level, then lowest index. Purely combinational.
// Assumes NUM_VEC <= NUM_SRC so every vector owns at least one source.
module intc_arbiter
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 96,
    parameter int NUM_VEC = 64,
    parameter int VW      = 6
) (
    input  logic [NUM_SRC-1:0]       active,
    input  prio_t [NUM_VEC-1:0]      prio,
    output logic                     win_valid,
    output logic [VW-1:0]            win_vec,
    output prio_t                    win_prio
);
    logic [NUM_VEC-1:0] pend;

    for (genvar v = 0; v < NUM_VEC; v++) begin : g_fold
        localparam int LO = first_src(v, NUM_SRC, NUM_VEC);
        localparam int HI = first_src(v + 1, NUM_SRC, NUM_VEC) - 1;
        assign pend[v] = |active[HI:LO];
    end

    // Descending scan with >= so that ties settle on the lowest index.
    always_comb begin
        win_valid = 1'b0;
        win_vec   = '0;
        win_prio  = '0;
        for (int v = NUM_VEC - 1; v >= 0; v--) begin
            if (pend[v] && (prio[v].main != 3'd0) &&
                (!win_valid || (prio[v] >= win_prio))) begin
                win_valid = 1'b1;
                win_vec   = VW'(v);
                win_prio  = prio[v];
            end
        end
    end
endmodule

// File: rtl/intc_core.sv
// Module: top of the interrupt controller. Holds control, level and status
// registers, decodes the register bus, gates the winner against the CPU
// level and registers the request. Assumes NUM_VEC <= 256 and that the
// flag, enable and level words fit their address windows.
module intc_core
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 96,
    parameter int NUM_VEC = 64,
    parameter int NUM_EXT = 5,
    localparam int VW = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_evt,
    input  logic [NUM_EXT-1:0] ext_pin,
    input  logic               bus_we,
    input  logic [7:0]         bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [2:0]         cpu_ipl,
    output logic               irq_req,
    output logic [VW-1:0]      irq_vec,
    output logic [2:0]         irq_prio
);
    localparam int NFW = (NUM_SRC + 31) / 32;
    localparam int NPW = (NUM_VEC + 3) / 4;

    logic               mode_multi;
    logic [NUM_EXT-1:0] ext_rise;
    prio_t [NUM_VEC-1:0] prio_q, prio_d;
    logic [VW-1:0]      stat_vec;
    logic [2:0]         stat_prio;

    logic [NUM_EXT-1:0] ext_evt;
    logic [NUM_SRC-1:0] hw_set, flag_q, en_q, active;
    logic               any_active;
    logic               win_valid;
    logic [VW-1:0]      win_vec;
    prio_t              win_prio;
    logic               req_d;
    logic               ctrl_hit;

    intc_ext_edge #(.NUM_EXT(NUM_EXT)) u_edge (
        .clk(clk), .rst_n(rst_n), .pin(ext_pin), .rise_sel(ext_rise), .evt(ext_evt)
    );

    assign hw_set = src_evt | NUM_SRC'(ext_evt);

    intc_src_bank #(.NUM_SRC(NUM_SRC)) u_bank (
        .clk(clk), .rst_n(rst_n), .hw_set(hw_set),
        .wr_en(bus_we), .wr_addr(bus_addr), .wr_data(bus_wdata),
        .flag_q(flag_q), .en_q(en_q)
    );

    assign active     = flag_q & en_q;
    assign any_active = |active;

    intc_arbiter #(.NUM_SRC(NUM_SRC), .NUM_VEC(NUM_VEC), .VW(VW)) u_arb (
        .active(active), .prio(prio_q),
        .win_valid(win_valid), .win_vec(win_vec), .win_prio(win_prio)
    );

    assign ctrl_hit = bus_we && (bus_addr == ADDR_CTRL);

    // Control register: reporting mode and external pin polarity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_multi <= 1'b0;
            ext_rise   <= '0;
        end else if (ctrl_hit) begin
            mode_multi <= bus_wdata[CTRL_MODE_BIT];
            ext_rise   <= bus_wdata[CTRL_POL_LSB +: NUM_EXT];
        end
    end

    for (genvar v = 0; v < NUM_VEC; v++) begin : g_prio
        localparam int WRD = v / 4;
        localparam int LSB = 8 * (v % 4);
        logic hit;
        assign hit       = bus_we && (bus_addr == ADDR_PRIO + AW'(WRD));
        assign prio_d[v] = hit ? prio_t'(bus_wdata[LSB +: 5]) : prio_q[v];
    end

    // Vector level storage.
    always_ff @(posedge clk) begin
        if (!rst_n) prio_q <= '0;
        else        prio_q <= prio_d;
    end

    assign req_d = win_valid && (win_prio.main > cpu_ipl);

    // Registered request towards the CPU and the status capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_req   <= 1'b0;
            irq_vec   <= '0;
            irq_prio  <= '0;
            stat_vec  <= '0;
            stat_prio <= '0;
        end else begin
            irq_req  <= req_d;
            irq_vec  <= (req_d && mode_multi) ? win_vec : '0;
            irq_prio <= req_d ? win_prio.main : 3'd0;
            if (req_d) begin
                stat_vec  <= mode_multi ? win_vec : '0;
                stat_prio <= win_prio.main;
            end
        end
    end

    logic [NFW*32-1:0] flag_pad, en_pad;
    logic [NPW*32-1:0] prio_pad;

    assign flag_pad = (NFW*32)'(flag_q);
    assign en_pad   = (NFW*32)'(en_q);

    // Pack vector levels into their bus bytes.
    always_comb begin
        prio_pad = '0;
        for (int v = 0; v < NUM_VEC; v++) begin
            prio_pad[32*(v/4) + 8*(v%4) +: 8] = {3'b000, prio_q[v]};
        end
    end

    // Read multiplexer over the whole register map.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_CTRL) begin
            bus_rdata[CTRL_MODE_BIT]              = mode_multi;
            bus_rdata[CTRL_POL_LSB +: NUM_EXT]    = ext_rise;
        end
        if (bus_addr == ADDR_STAT) begin
            bus_rdata[7:0]  = 8'(stat_vec);
            bus_rdata[10:8] = stat_prio;
        end
        for (int w = 0; w < NFW; w++) begin
            if (bus_addr == ADDR_FLAG + AW'(w)) bus_rdata = flag_pad[32*w +: 32];
            if (bus_addr == ADDR_EN + AW'(w))   bus_rdata = en_pad[32*w +: 32];
        end
        for (int w = 0; w < NPW; w++) begin
            if (bus_addr == ADDR_PRIO + AW'(w)) bus_rdata = prio_pad[32*w +: 32];
        end
    end
endmodule

// File: rtl/intc_core_chk.sv
// Module: assertion checker bound to intc_core. Observes ports and the
// control and status registers; drives nothing.
module intc_core_chk #(
    parameter int NUM_VEC = 64,
    parameter int VW      = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    cpu_ipl,
    input logic          irq_req,
    input logic [VW-1:0] irq_vec,
    input logic [2:0]    irq_prio,
    input logic          mode_multi,
    input logic [VW-1:0] stat_vec,
    input logic [2:0]    stat_prio,
    input logic          any_active
);
    AST_REQ_ABOVE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_prio > $past(cpu_ipl)));                          // R1
    AST_REQ_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> $past(any_active));                                    // R5
    AST_NO_ZERO_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_prio != 3'd0));                                   // R3
    AST_SINGLE_MODE_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !$past(mode_multi)) |-> (irq_vec == '0));              // R7
    AST_STATUS_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (stat_vec == irq_vec && stat_prio == irq_prio));       // R9
    AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_req && $past(rst_n)) |-> ($stable(stat_vec) && $stable(stat_prio))); // R9
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req |-> (irq_vec == '0 && irq_prio == 3'd0));                 // R10
    AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (int'(irq_vec) < NUM_VEC));                            // R5
endmodule

bind intc_core intc_core_chk #(.NUM_VEC(NUM_VEC), .VW(VW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_ipl(cpu_ipl), .irq_req(irq_req),
    .irq_vec(irq_vec), .irq_prio(irq_prio), .mode_multi(mode_multi),
    .stat_vec(stat_vec), .stat_prio(stat_prio), .any_active(any_active)
);

// File: tb/intc_core_bench.sv
// Bench: behavioural reference model updated on every rising edge and
// compared with all outputs on every falling edge.
module intc_core_bench;
    localparam int S  = 12;
    localparam int V  = 8;
    localparam int E  = 3;
    localparam int VWB = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic [S-1:0]  d_evt = '0;
    logic [E-1:0]  d_pin = '0;
    logic          d_we = 1'b0;
    logic [7:0]    d_addr = '0;
    logic [31:0]   d_wdata = '0;
    logic [2:0]    d_ipl = '0;
    logic [31:0]   bus_rdata;
    logic          irq_req;
    logic [VWB-1:0] irq_vec;
    logic [2:0]    irq_prio;

    intc_core #(.NUM_SRC(S), .NUM_VEC(V), .NUM_EXT(E)) u_intc_core (
        .clk(clk), .rst_n(rst_n), .src_evt(d_evt), .ext_pin(d_pin),
        .bus_we(d_we), .bus_addr(d_addr), .bus_wdata(d_wdata),
        .bus_rdata(bus_rdata), .cpu_ipl(d_ipl), .irq_req(irq_req),
        .irq_vec(irq_vec), .irq_prio(irq_prio)
    );

    int errors = 0;
    int checks = 0;
    string tag = "R3";

    // Reference state
    bit m_flag[S], m_en[S];
    int m_main[V], m_sub[V];
    bit m_mode;
    bit m_pol[E], m_s1[E], m_s2[E], m_pv[E];
    bit m_req;
    int m_vec, m_pr, m_sv, m_sp;

    function automatic int vec_of(int s);
        return (s * V) / S;
    endfunction

    task automatic model_update();
        int best, i;
        bit edge_seen[E];
        bit pend, req;
        if (!rst_n) begin
            foreach (m_flag[k]) begin m_flag[k] = 0; m_en[k] = 0; end
            foreach (m_main[k]) begin m_main[k] = 0; m_sub[k] = 0; end
            foreach (m_pol[k]) begin m_pol[k] = 0; m_s1[k] = 0; m_s2[k] = 0; m_pv[k] = 0; end
            m_mode = 0; m_req = 0; m_vec = 0; m_pr = 0; m_sv = 0; m_sp = 0;
            return;
        end
        for (i = 0; i < E; i++)
            edge_seen[i] = m_pol[i] ? (m_s2[i] && !m_pv[i]) : (!m_s2[i] && m_pv[i]);
        best = -1;
        for (int v = 0; v < V; v++) begin
            pend = 0;
            for (int s = 0; s < S; s++)
                if (vec_of(s) == v && m_flag[s] && m_en[s]) pend = 1;
            if (pend && m_main[v] > 0) begin
                if (best < 0 || m_main[v] > m_main[best] ||
                    (m_main[v] == m_main[best] && m_sub[v] > m_sub[best]))
                    best = v;
            end
        end
        req = (best >= 0) && (m_main[best] > int'(d_ipl));
        m_req = req;
        m_vec = req ? (m_mode ? best : 0) : 0;
        m_pr  = req ? m_main[best] : 0;
        if (req) begin m_sv = m_vec; m_sp = m_pr; end
        for (int s = 0; s < S; s++) begin
            bit nf;
            nf = m_flag[s];
            if (d_we && int'(d_addr) == 16 + s / 32) nf = d_wdata[s % 32];
            if (d_evt[s]) nf = 1;
            if (s < E && edge_seen[s]) nf = 1;
            m_flag[s] = nf;
            if (d_we && int'(d_addr) == 32 + s / 32) m_en[s] = d_wdata[s % 32];
        end
        for (int v = 0; v < V; v++)
            if (d_we && int'(d_addr) == 64 + v / 4) begin
                m_main[v] = (d_wdata >> (8 * (v % 4) + 2)) & 7;
                m_sub[v]  = (d_wdata >> (8 * (v % 4))) & 3;
            end
        if (d_we && d_addr == 8'h00) begin
            m_mode = d_wdata[0];
            for (i = 0; i < E; i++) m_pol[i] = d_wdata[8 + i];
        end
        for (i = 0; i < E; i++) begin
            m_pv[i] = m_s2[i]; m_s2[i] = m_s1[i]; m_s1[i] = d_pin[i];
        end
    endtask

    function automatic logic [31:0] exp_read(logic [7:0] a);
        logic [31:0] r;
        r = '0;
        if (a == 8'h00) begin
            r[0] = m_mode;
            for (int i = 0; i < E; i++) r[8 + i] = m_pol[i];
        end else if (a == 8'h01) begin
            r = 32'(m_sv) | (32'(m_sp) << 8);
        end else begin
            for (int s = 0; s < S; s++) begin
                if (int'(a) == 16 + s / 32) r[s % 32] = m_flag[s];
                if (int'(a) == 32 + s / 32) r[s % 32] = m_en[s];
            end
            for (int v = 0; v < V; v++)
                if (int'(a) == 64 + v / 4)
                    r[8 * (v % 4) +: 5] = 5'((m_main[v] << 2) | m_sub[v]);
        end
        return r;
    endfunction

    task automatic check(string sig, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h at %0t", tag, sig, got, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_update();
        @(negedge clk);
        check("irq_req", 32'(irq_req), 32'(m_req));
        check("irq_vec", 32'(irq_vec), 32'(m_vec));
        check("irq_prio", 32'(irq_prio), 32'(m_pr));
        check("bus_rdata", bus_rdata, exp_read(d_addr));
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        d_we = 1'b1; d_addr = a; d_wdata = d;
        tick();
        d_we = 1'b0;
    endtask

    task automatic rd(logic [7:0] a);
        d_addr = a;
        tick();
    endtask

    task automatic pulse(int s);
        d_evt = S'(1) << s;
        tick();
        d_evt = '0;
    endtask

    function automatic logic [31:0] lvl(int main, int sub, int slot);
        return 32'((main << 2) | sub) << (8 * slot);
    endfunction

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R3: reset state
        tag = "R3";
        idle(3);
        @(negedge clk); rst_n = 1'b1;
        rd(8'h00); rd(8'h01); rd(8'h10); rd(8'h20); rd(8'h40); rd(8'h41);
        pulse(5); idle(3);

        // R1: level gating; vector 3 (source 5) at main 3
        tag = "R1";
        wr(8'h20, 32'h1 << 5);
        wr(8'h40, lvl(3, 0, 3));
        d_ipl = 3'd3; idle(3);
        d_ipl = 3'd2; idle(3); rd(8'h01);
        d_ipl = 3'd3; idle(2);
        d_ipl = 3'd0; idle(2);

        // R7: multi-vector mode
        tag = "R7";
        wr(8'h00, 32'h1); idle(2);
        wr(8'h00, 32'h0); idle(2);
        wr(8'h00, 32'h1); idle(1);

        // R6: clear by write, and set wins over a clear in the same cycle
        tag = "R6";
        wr(8'h10, 32'h0); idle(2); rd(8'h10);
        d_evt = S'(1) << 5; wr(8'h10, 32'h0); d_evt = '0; rd(8'h10); idle(2);
        wr(8'h10, 32'h0); idle(2);

        // R2: main, then sub order
        tag = "R2";
        wr(8'h20, 32'hFFF);
        wr(8'h40, lvl(2, 1, 1));
        wr(8'h41, lvl(2, 3, 1) | lvl(5, 0, 2));
        pulse(2); pulse(8); pulse(9); idle(2); rd(8'h41);
        wr(8'h10, 32'h1 << 8 | 32'h1 << 2); idle(2);
        wr(8'h10, 32'h1 << 2); idle(2);
        rd(8'h01);

        // R4: equal levels, lowest index wins
        tag = "R4";
        wr(8'h41, lvl(2, 1, 1));
        pulse(8); idle(2); rd(8'h01);
        wr(8'h10, 32'h0); idle(2);

        // R3: main level zero never delivers
        tag = "R3";
        pulse(11); idle(3);
        wr(8'h10, 32'h0);

        // R5: shared vector 2 from sources 3 and 4, enable gating
        tag = "R5";
        wr(8'h40, lvl(4, 2, 2));
        pulse(4); idle(2); wr(8'h10, 32'h0); idle(2);
        pulse(3); idle(2);
        wr(8'h20, 32'hFFF & ~(32'h1 << 3)); idle(2);
        wr(8'h20, 32'hFFF); idle(2);
        wr(8'h10, 32'h0); idle(1);

        // R8: external pins, rising on pin 0, falling on pin 1
        tag = "R8";
        wr(8'h00, 32'h1 | (32'h1 << 8));
        wr(8'h40, lvl(6, 0, 0));
        d_pin = 3'b001; idle(5); rd(8'h10);
        wr(8'h10, 32'h0);
        d_pin = 3'b000; idle(5); rd(8'h10);
        d_pin = 3'b010; idle(5); rd(8'h10);
        d_pin = 3'b000; idle(5); rd(8'h10);
        wr(8'h10, 32'h0); idle(2);

        // R9: status holds and ignores writes
        tag = "R9";
        rd(8'h01);
        wr(8'h01, 32'hFFFF_FFFF); rd(8'h01);

        // R10 / R1: long mixed stimulus
        tag = "R10";
        for (int n = 0; n < 4000; n++) begin
            d_ipl = 3'($urandom_range(0, 7));
            d_evt = ($urandom_range(0, 3) == 0) ? S'(1) << $urandom_range(0, S - 1) : '0;
            d_pin = 3'($urandom);
            if ($urandom_range(0, 4) == 0) begin
                int pick;
                pick = $urandom_range(0, 5);
                d_we = 1'b1;
                d_addr = (pick == 0) ? 8'h00 : (pick == 1) ? 8'h01 :
                         (pick == 2) ? 8'h10 : (pick == 3) ? 8'h20 :
                         (pick == 4) ? 8'h40 : 8'h41;
                d_wdata = $urandom;
            end else begin
                int pick;
                pick = $urandom_range(0, 5);
                d_we = 1'b0;
                d_addr = (pick == 0) ? 8'h00 : (pick == 1) ? 8'h01 :
                         (pick == 2) ? 8'h10 : (pick == 3) ? 8'h20 :
                         (pick == 4) ? 8'h40 : 8'h41;
            end
            tick();
        end
        d_we = 1'b0; d_evt = '0;
        idle(2);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule